// File: doc/BRIEF.md
# Oscillation-Test Boundary Wrapper Chain

This block places a chain of boundary wrapper cells around one core: a group of input-pin cells that sit between chip-level wires and the core inputs, and a group of output-pin cells that sit between the core outputs and the outgoing wires. With the test enable low, each cell forwards functional data between pin and core and offers a shift stage in a serial scan chain. With the test enable high, each cell opens combinational paths so that a closed loop can be formed through outgoing wires, incoming wires and this wrapper's scan path. Each input cell then forwards either its pin or the upstream chain signal. Each output cell drives its pin from the chain signal, true or inverted, and passes the chain signal on unchanged.

The choice made by each cell is set by one configuration bit. Input cells hold a route bit, and output cells hold a polarity bit that sets the parity of the loop. These bits are shifted in through the scan chain and then copied into a shadow stage by an update strobe, so that shifting does not disturb a running configuration. During oscillation test the values presented to the core are frozen, and the shift and shadow stages ignore their strobes.

Top module: `osc_wrap_chain`

## Requirements
- R1: After reset every shift stage, every configuration bit and every frozen core-side value is 0. Configuration 0 means route-from-chain for input cells and non-inverting for output cells.
- R2: With `osc_en` low, `core_in[i]` follows `pin_in[i]` and `pin_out[j]` follows `core_out[j]` with no clock.
- R3: With `osc_en` low and `shift_en` high, each rising clock edge moves the data one stage along the chain. Input cells 0..N_IN-1 come first, then output cells, and `scan_in` enters cell 0. `scan_out` shows the shift stage of the last cell.
- R4: A configuration bit takes the value of its cell's shift stage only on a clock edge where `update_en` is high and `osc_en` is low. Shifting alone leaves the active configuration unchanged.
- R5: With `osc_en` high and route bit 1, an input cell drives its chain output from its own `pin_in`, non-inverted.
- R6: With `osc_en` high and route bit 0, an input cell drives its chain output from its chain input, non-inverted.
- R7: With `osc_en` high, an output cell drives `pin_out` with its chain input XOR its polarity bit (1 = invert). It passes the chain input unchanged to its chain output. All of these paths are combinational, so `scan_out` follows `scan_in` or a pin with no clock.
- R8: While `osc_en` is high, `core_in` holds the value `pin_in` had at the last clock edge before test entry, whatever the pins do.
- R9: While `osc_en` is high, `shift_en` and `update_en` have no effect. Shift contents and configuration are unchanged when the test ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock for shift, shadow and hold stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial chain input, and loop input during test |
| shift_en | input | 1 | Advance the chain one stage per clock |
| update_en | input | 1 | Copy shift stages into configuration bits |
| osc_en | input | 1 | Global oscillation-test enable |
| pin_in | input | N_IN | Incoming wires at the input cells |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_OUT | Values driven by the core outputs |
| pin_out | output | N_OUT | Outgoing wires at the output cells |
| scan_out | output | 1 | Serial chain output, and loop output during test |

## Verification
The bench builds the chain with four input cells and four output cells. With that size, any mix of route and polarity bits can be loaded in one eight-bit shift. It can also put an input cell that breaks the chain both upstream and downstream of a non-breaking one. A vector table sweeps route, polarity, pin and chain-input combinations and compares every loop path against a model of R5 to R7. Directed sequences cover the reset values, shadow isolation, strobes ignored during test and the core-side freeze.

// File: rtl/osc_wrap_pkg.sv
package osc_wrap_pkg;

  // Route choice of an input cell during oscillation test
  typedef enum logic {
    RT_CHAIN = 1'b0,
    RT_PIN   = 1'b1
  } route_t;

  // Polarity choice of an output cell during oscillation test
  typedef enum logic {
    POL_TRUE   = 1'b0,
    POL_INVERT = 1'b1
  } pol_t;

endpackage

// File: rtl/osc_cfg_stage.sv
// Shift stage plus shadow configuration bit shared by both cell kinds.
module osc_cfg_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic shift_en,
  input  logic update_en,
  input  logic osc_en,
  output logic sh_q,
  output logic cfg_q
);

  logic sh_d;
  logic cfg_d;
  logic sh_ce;
  logic cfg_ce;

  always_comb begin
    sh_ce  = shift_en  & ~osc_en;
    cfg_ce = update_en & ~osc_en;
    sh_d   = sh_ce  ? si   : sh_q;
    cfg_d  = cfg_ce ? sh_q : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= 1'b0;
      cfg_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
    end
  end

  // R3: a shift edge in normal mode captures the upstream bit
  assert_shift_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !osc_en) |=> (sh_q == $past(si)));

  // R4: without an update strobe the configuration bit holds
  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(cfg_q));

  // R9: strobes are ignored while the test enable is high
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |=> ($stable(cfg_q) && $stable(sh_q)));

endmodule

// File: rtl/osc_in_cell.sv
// Input-pin wrapper cell: pin -> core, with a routable loop path.
module osc_in_cell
  import osc_wrap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic shift_en,
  input  logic update_en,
  input  logic osc_en,
  input  logic pin_in,
  output logic core_in,
  output logic so
);

  logic   sh_q;
  logic   cfg_q;
  logic   held_q;
  logic   held_d;
  route_t route;
  logic   loop_src;

  osc_cfg_stage u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .si        (si),
    .shift_en  (shift_en),
    .update_en (update_en),
    .osc_en    (osc_en),
    .sh_q      (sh_q),
    .cfg_q     (cfg_q)
  );

  // Hold stage: tracks the pin in normal mode, frozen during test
  always_comb begin
    held_d = osc_en ? held_q : pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

  // Path selection muxes
  always_comb begin
    route    = route_t'(cfg_q);
    loop_src = (route == RT_PIN) ? pin_in : si;
    core_in  = osc_en ? held_q : pin_in;
    so       = osc_en ? loop_src : sh_q;
  end

  // R8: the core-side value is frozen across consecutive test cycles
  assert_core_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && $past(osc_en)) |-> $stable(core_in));

endmodule

// File: rtl/osc_out_cell.sv
// Output-pin wrapper cell: core -> pin, with a polarity-controlled loop path.
module osc_out_cell
  import osc_wrap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic shift_en,
  input  logic update_en,
  input  logic osc_en,
  input  logic core_out,
  output logic pin_out,
  output logic so
);

  logic sh_q;
  logic cfg_q;
  pol_t pol;
  logic loop_drv;

  osc_cfg_stage u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .si        (si),
    .shift_en  (shift_en),
    .update_en (update_en),
    .osc_en    (osc_en),
    .sh_q      (sh_q),
    .cfg_q     (cfg_q)
  );

  always_comb begin
    pol      = pol_t'(cfg_q);
    loop_drv = (pol == POL_INVERT) ? ~si : si;
    pin_out  = osc_en ? loop_drv : core_out;
    so       = osc_en ? si : sh_q;
  end

endmodule

// File: rtl/osc_wrap_chain.sv
// Wrapper chain around one core: input cells first, then output cells.
module osc_wrap_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_in,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             osc_en,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out,
  output logic             scan_out
);

  localparam int LEN = N_IN + N_OUT;

  logic [LEN:0] link;

  assign link[0]  = scan_in;
  assign scan_out = link[LEN];

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    osc_in_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .si        (link[i]),
      .shift_en  (shift_en),
      .update_en (update_en),
      .osc_en    (osc_en),
      .pin_in    (pin_in[i]),
      .core_in   (core_in[i]),
      .so        (link[i+1])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    osc_out_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .si        (link[N_IN+j]),
      .shift_en  (shift_en),
      .update_en (update_en),
      .osc_en    (osc_en),
      .core_out  (core_out[j]),
      .pin_out   (pin_out[j]),
      .so        (link[N_IN+j+1])
    );
  end

endmodule

// File: tb/sim_osc_wrap_chain.sv
module sim_osc_wrap_chain;

  localparam int CLK_P = 10;
  localparam int NI = 4;
  localparam int NO = 4;

  // Stimulus vectors: {route[3:0], polarity[3:0], pin_in[3:0], scan_in}
  localparam logic [12:0] VEC [12] = '{
    {4'b0000, 4'b0000, 4'b0000, 1'b1},
    {4'b0000, 4'b1111, 4'b1111, 1'b1},
    {4'b0000, 4'b1010, 4'b0000, 1'b0},
    {4'b0001, 4'b0000, 4'b0001, 1'b0},
    {4'b0001, 4'b0101, 4'b0000, 1'b1},
    {4'b1000, 4'b0011, 4'b1000, 1'b0},
    {4'b1000, 4'b1100, 4'b0111, 1'b1},
    {4'b0100, 4'b1001, 4'b0100, 1'b0},
    {4'b0110, 4'b0110, 4'b0010, 1'b1},
    {4'b1111, 4'b0001, 4'b0111, 1'b0},
    {4'b1111, 4'b1110, 4'b1000, 1'b1},
    {4'b0010, 4'b1111, 4'b1101, 1'b0}
  };

  logic          clk;
  logic          rst_n;
  logic          scan_in;
  logic          shift_en;
  logic          update_en;
  logic          osc_en;
  logic [NI-1:0] pin_in;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] pin_out;
  logic          scan_out;

  int n_chk;
  int n_bad;
  bit done;

  osc_wrap_chain #(.N_IN(NI), .N_OUT(NO)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_in   (scan_in),
    .shift_en  (shift_en),
    .update_en (update_en),
    .osc_en    (osc_en),
    .pin_in    (pin_in),
    .core_in   (core_in),
    .core_out  (core_out),
    .pin_out   (pin_out),
    .scan_out  (scan_out)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Loop-path model from R5..R7: returns {scan_out, pin_out[3:0]}
  function automatic logic [4:0] model(input logic [3:0] rt, input logic [3:0] pol,
                                       input logic [3:0] pin, input logic si);
    logic       x;
    logic [3:0] po;
    x = si;
    for (int i = 0; i < 4; i++) if (rt[i]) x = pin[i];
    for (int j = 0; j < 4; j++) po[j] = x ^ pol[j];
    return {x, po};
  endfunction

  // Shift 8 bits so that cell k ends holding c[k]
  task automatic shift_word(input logic [7:0] c);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      shift_en = 1'b1;
      scan_in  = c[7-j];
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic load_cfg(input logic [3:0] rt, input logic [3:0] pol);
    shift_word({pol, rt});
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
  endtask

  // Starting at a negedge, read cell 7 down to cell 0 through scan_out
  task automatic unload_chk(input logic [7:0] c, input string req);
    for (int j = 0; j < 8; j++) begin
      if (j > 0) @(negedge clk);
      #1;
      chk(req, {7'd0, scan_out}, {7'd0, c[7-j]});
      shift_en = 1'b1;
      scan_in  = 1'b0;
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; scan_in = 1'b1; shift_en = 1'b0; update_en = 1'b0;
    osc_en = 1'b1; pin_in = 4'hF; core_out = 4'h0;

    // R1: reset values seen through the test-mode paths
    repeat (2) @(negedge clk);
    #1;
    chk("R1 core_in frozen value", {4'd0, core_in}, 8'h00);
    chk("R1 pin_out non-inverted", {4'd0, pin_out}, 8'h0F);
    chk("R1 route from chain", {7'd0, scan_out}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1; osc_en = 1'b0;
    #1;
    chk("R1 shift stages clear", {7'd0, scan_out}, 8'h00);

    // R2: functional pass-through
    pin_in = 4'h6; core_out = 4'h9;
    #1;
    chk("R2 core_in follows pin", {4'd0, core_in}, 8'h06);
    chk("R2 pin_out follows core", {4'd0, pin_out}, 8'h09);

    // R3: shift one stage per edge, read back in order
    shift_word(8'b1011_0010);
    unload_chk(8'b1011_0010, "R3 shift order");

    // R5/R6/R7: vector table of loop-path combinations
    for (int v = 0; v < 12; v++) begin
      logic [4:0] e;
      load_cfg(VEC[v][12:9], VEC[v][8:5]);
      osc_en = 1'b1;
      pin_in = VEC[v][4:1];
      scan_in = VEC[v][0];
      #1;
      e = model(VEC[v][12:9], VEC[v][8:5], VEC[v][4:1], VEC[v][0]);
      chk("R5 R6 R7 loop paths", {3'd0, scan_out, pin_out}, {3'd0, e});
      // R7: combinational, flip chain input with no clock
      scan_in = ~VEC[v][0];
      #1;
      e = model(VEC[v][12:9], VEC[v][8:5], VEC[v][4:1], ~VEC[v][0]);
      chk("R7 no-clock response", {3'd0, scan_out, pin_out}, {3'd0, e});
      @(negedge clk);
      osc_en = 1'b0;
    end

    // R4: shifting without update leaves the active configuration
    load_cfg(4'b0101, 4'b0011);
    shift_word(8'b1100_1010);
    osc_en = 1'b1; pin_in = 4'b1001; scan_in = 1'b1;
    #1;
    chk("R4 config unchanged by shift", {3'd0, scan_out, pin_out},
        {3'd0, model(4'b0101, 4'b0011, 4'b1001, 1'b1)});

    // R9: strobes during test have no effect
    @(negedge clk);
    shift_en = 1'b1; update_en = 1'b1; scan_in = 1'b0;
    repeat (3) @(negedge clk);
    shift_en = 1'b0; update_en = 1'b0; scan_in = 1'b1;
    #1;
    chk("R9 config kept in test", {3'd0, scan_out, pin_out},
        {3'd0, model(4'b0101, 4'b0011, 4'b1001, 1'b1)});
    @(negedge clk);
    osc_en = 1'b0;
    unload_chk(8'b1100_1010, "R9 shift kept in test");

    // R8: core-side freeze
    pin_in = 4'hA; core_out = 4'h5;
    @(negedge clk);
    @(negedge clk);
    osc_en = 1'b1; pin_in = 4'h3;
    #1;
    chk("R8 freeze on entry", {4'd0, core_in}, 8'h0A);
    repeat (2) @(negedge clk);
    pin_in = 4'hC;
    #1;
    chk("R8 freeze held", {4'd0, core_in}, 8'h0A);
    osc_en = 1'b0;
    #1;
    chk("R2 pass-through after test", {4'd0, core_in}, 8'h0C);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule